// File: doc/BRIEF.md
# Conversion Complete Flag Controller

This block keeps one completion flag for each result slot of an analog-to-digital converter's register interface. When the converter delivers a sample, it stores the sample in the slot's result register and sets that slot's flag. Software clears flags in one of two ways. A control bit chooses between them: writing ones into the flag register, or a fast mode in which an access to the result register itself clears the flag.

In fast mode, a per-slot compare-enable bit decides which kind of access counts. A slot without compare is cleared by a read of its result. A slot with compare is cleared by a write to its result, which in that case carries a reference value. The block also holds the 8-bit converter control register. Every write to that register sends a one-cycle abort pulse to the conversion sequencer.

The bus is a single-cycle register port. An access takes place when `bus_sel` is high, and `bus_wr` tells a write from a read. Read data is combinational from the current state.

Top module: `cvflag_bank`

## Requirements
- R1: After reset the control, flag, compare-enable and all result registers read zero, and `seq_abort_o` is low.
- R2: The control register is at word address 0. Bits 6..0 read back what was last written. Bit 7 always reads zero. `ctrl_o` shows the same value.
- R3: Each write to the control register, whatever its value, drives `seq_abort_o` high in exactly the next cycle. A cycle with no control write leaves it low in the next cycle.
- R4: A `cv_done` pulse stores `cv_result` into slot `cv_slot` and sets flag bit `cv_slot` of the flag register at address 1. Slot s is read at address 16+s, zero-extended.
- R5: With fast-clear off (control bit 6 = 0), writing the flag register clears every flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R6: With fast-clear on, writes to the flag register change no flag.
- R7: With fast-clear on and the slot's compare-enable bit at 0, a read of that slot's result clears its flag, and a write of it does not.
- R8: With fast-clear on and the slot's compare-enable bit at 1, a write of that slot's result clears its flag, and a read of it does not.
- R9: With fast-clear off, reads and writes of result registers change no flag.
- R10: If a set and any clear reach the same flag in the same cycle, the flag ends up set.
- R11: The compare-enable register at address 2 holds all 16 bits written to it. Bit s belongs to slot s.
- R12: A bus write to a result register stores the low 12 data bits. If `cv_done` targets the same slot in that cycle, the converter's value is stored.
- R13: Reads of unmapped addresses return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| cv_done | input | 1 | Converter delivers a result this cycle |
| cv_slot | input | 4 | Slot receiving the result |
| cv_result | input | 12 | Converted value |
| flags_o | output | 16 | Current completion flags |
| ctrl_o | output | 8 | Current control register |
| seq_abort_o | output | 1 | One-cycle sequence abort request |

## Verification
The clearing logic is exercised in each of its four regimes: fast-clear off, and fast-clear on with compare off or on. In each regime, both result reads and result writes are applied to flagged slots, so each regime shows which access clears and which is ignored. Flag-register writes use data patterns that mix ones and zeros. These show that single bits are cleared, that zero bits do no harm, and that the whole write is ignored in fast mode. Same-cycle collisions of set with clear, and of a converter write with a bus write, separate the priority orders. A long mixed stream with interleaved control writes then compares every cycle against a behavioural model, which catches abort timing and stray state changes.

// File: rtl/cvflag_pkg.sv
`timescale 1ns/1ps
package cvflag_pkg;
   localparam int CTRL_W = 8;

   typedef struct packed {
      logic rsvd;
      logic fast_clr;
      logic clk_in_stop;
      logic trig_level;
      logic trig_pol;
      logic trig_en;
      logic seq_ie;
      logic cmp_ie;
   } ctrl_t;
endpackage

// File: rtl/cvflag_ctrl_reg.sv
`timescale 1ns/1ps
module cvflag_ctrl_reg
   import cvflag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output ctrl_t             ctrl_o,
   output logic              abort_o
);
   ctrl_t ctrl_q;
   logic  abort_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= wr_i;
         if (wr_i) begin
            ctrl_q      <= ctrl_t'(wdata_i);
            ctrl_q.rsvd <= 1'b0;
         end
      end
   end

   assign ctrl_o  = ctrl_q;
   assign abort_o = abort_q;

   AST_ABORT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> abort_o); // R3
   AST_NO_STRAY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> !abort_o); // R3
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ctrl_o)); // R2
endmodule

// File: rtl/cvflag_word_reg.sv
`timescale 1ns/1ps
module cvflag_word_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (wr_i) q <= wdata_i;
   end

   assign q_o = q;

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(q_o)); // R11
endmodule

// File: rtl/cvflag_slot.sv
`timescale 1ns/1ps
module cvflag_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_i,
   input  logic cmpen_i,
   input  logic set_i,
   input  logic wr_one_i,
   input  logic res_rd_i,
   input  logic res_wr_i,
   output logic flag_o
);
   logic flag_q;
   logic clr;

   always_comb begin
      if (fast_i) clr = cmpen_i ? res_wr_i : res_rd_i;
      else        clr = wr_one_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R10
   AST_SLOW_ACCESS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_i && flag_o && !wr_one_i) |=> flag_o); // R9
   AST_FAST_FLAGWR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_i && flag_o && !res_rd_i && !res_wr_i) |=> flag_o); // R6
   AST_FAST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_i && !cmpen_i && res_rd_i && !set_i) |=> !flag_o); // R7
   AST_FAST_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_i && cmpen_i && res_wr_i && !set_i) |=> !flag_o); // R8
endmodule

// File: rtl/cvflag_result_bank.sv
`timescale 1ns/1ps
module cvflag_result_bank #(
   parameter int NUM_SLOTS = 16,
   parameter int RES_W     = 12,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_we_i,
   input  logic [SLOT_W-1:0] cv_idx_i,
   input  logic [RES_W-1:0]  cv_data_i,
   input  logic              bus_we_i,
   input  logic [SLOT_W-1:0] bus_idx_i,
   input  logic [RES_W-1:0]  bus_data_i,
   input  logic [SLOT_W-1:0] rd_idx_i,
   output logic [RES_W-1:0]  rd_data_o
);
   logic [RES_W-1:0] res_q [NUM_SLOTS];

   always_ff @(posedge clk) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (!rst_n)
            res_q[s] <= '0;
         else if (cv_we_i && cv_idx_i == SLOT_W'(s))
            res_q[s] <= cv_data_i;
         else if (bus_we_i && bus_idx_i == SLOT_W'(s))
            res_q[s] <= bus_data_i;
      end
   end

   assign rd_data_o = res_q[rd_idx_i];

   AST_CV_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      cv_we_i |=> res_q[$past(cv_idx_i)] == $past(cv_data_i)); // R4
   AST_BUS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && !(cv_we_i && cv_idx_i == bus_idx_i))
      |=> res_q[$past(bus_idx_i)] == $past(bus_data_i)); // R12
endmodule

// File: rtl/cvflag_bank.sv
`timescale 1ns/1ps
module cvflag_bank
   import cvflag_pkg::*;
#(
   parameter int NUM_SLOTS  = 16,
   parameter int DATA_W     = 16,
   parameter int RES_W      = 12,
   parameter int ADDR_W     = 6,
   parameter int CTRL_ADDR  = 0,
   parameter int FLAG_ADDR  = 1,
   parameter int CMPEN_ADDR = 2,
   parameter int RES_BASE   = 16,
   localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cv_done,
   input  logic [SLOT_W-1:0] cv_slot,
   input  logic [RES_W-1:0]  cv_result,
   output logic [NUM_SLOTS-1:0] flags_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              seq_abort_o
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] A_CMPEN = ADDR_W'(CMPEN_ADDR);
   localparam logic [ADDR_W-1:0] A_RES_LO = ADDR_W'(RES_BASE);
   localparam logic [ADDR_W-1:0] A_RES_HI = ADDR_W'(RES_BASE + NUM_SLOTS - 1);

   if (NUM_SLOTS > DATA_W) begin : g_bad_slots
      $error("NUM_SLOTS must not exceed DATA_W");
   end
   if ((1 << SLOT_W) != NUM_SLOTS) begin : g_bad_pow2
      $error("NUM_SLOTS must be a power of two");
   end
   if (DATA_W < CTRL_W || RES_W > DATA_W) begin : g_bad_width
      $error("DATA_W must cover control and result widths");
   end
   if (RES_BASE + NUM_SLOTS > (1 << ADDR_W)) begin : g_bad_map
      $error("result window exceeds address space");
   end

   logic acc_rd, acc_wr;
   logic hit_ctrl, hit_flag, hit_cmpen, hit_res;
   logic [SLOT_W-1:0] res_idx;

   assign acc_rd    = bus_sel & ~bus_wr;
   assign acc_wr    = bus_sel &  bus_wr;
   assign hit_ctrl  = (bus_addr == A_CTRL);
   assign hit_flag  = (bus_addr == A_FLAG);
   assign hit_cmpen = (bus_addr == A_CMPEN);
   assign hit_res   = (bus_addr >= A_RES_LO) && (bus_addr <= A_RES_HI);
   assign res_idx   = SLOT_W'(bus_addr - A_RES_LO);

   ctrl_t ctrl_q;
   logic  ctrl_wr;
   assign ctrl_wr = acc_wr & hit_ctrl;

   cvflag_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ctrl_wr),
      .wdata_i (bus_wdata[CTRL_W-1:0]),
      .ctrl_o  (ctrl_q),
      .abort_o (seq_abort_o)
   );

   logic [NUM_SLOTS-1:0] cmpen_q;
   logic                 cmpen_wr;
   assign cmpen_wr = acc_wr & hit_cmpen;

   cvflag_word_reg #(.W(NUM_SLOTS)) u_cmpen (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cmpen_wr),
      .wdata_i (bus_wdata[NUM_SLOTS-1:0]),
      .q_o     (cmpen_q)
   );

   logic             res_wr, res_rd;
   logic [RES_W-1:0] res_rd_data;
   assign res_wr = acc_wr & hit_res;
   assign res_rd = acc_rd & hit_res;

   cvflag_result_bank #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .cv_we_i    (cv_done),
      .cv_idx_i   (cv_slot),
      .cv_data_i  (cv_result),
      .bus_we_i   (res_wr),
      .bus_idx_i  (res_idx),
      .bus_data_i (bus_wdata[RES_W-1:0]),
      .rd_idx_i   (res_idx),
      .rd_data_o  (res_rd_data)
   );

   logic flag_wr;
   assign flag_wr = acc_wr & hit_flag;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      cvflag_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .fast_i   (ctrl_q.fast_clr),
         .cmpen_i  (cmpen_q[s]),
         .set_i    (cv_done && cv_slot == SLOT_W'(s)),
         .wr_one_i (flag_wr && bus_wdata[s]),
         .res_rd_i (res_rd && res_idx == SLOT_W'(s)),
         .res_wr_i (res_wr && res_idx == SLOT_W'(s)),
         .flag_o   (flags_o[s])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl)       bus_rdata = DATA_W'(ctrl_q);
      else if (hit_flag)  bus_rdata = DATA_W'(flags_o);
      else if (hit_cmpen) bus_rdata = DATA_W'(cmpen_q);
      else if (hit_res)   bus_rdata = DATA_W'(res_rd_data);
   end

   assign ctrl_o = ctrl_q;

   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cv_done |=> flags_o[$past(cv_slot)]); // R4
   AST_UNMAPPED_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !hit_ctrl && !hit_flag && !hit_cmpen && !hit_res)
      |-> bus_rdata == '0); // R13
endmodule

// File: tb/cvflag_bank_bench.sv
`timescale 1ns/1ps
module cvflag_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cv_done = 1'b0;
   logic [3:0]  cv_slot = '0;
   logic [11:0] cv_result = '0;
   logic [15:0] flags_o;
   logic [7:0]  ctrl_o;
   logic        seq_abort_o;

   cvflag_bank u_cvflag_bank (.*);

   always #4 clk = ~clk;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    n_cyc   = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic [7:0]  m_ctrl;
   logic [15:0] m_flags, m_cmp;
   logic [11:0] m_res [16];
   logic        m_abort;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] m_read(input logic [5:0] a);
      if (a == 6'd0)      return {8'h00, m_ctrl};
      else if (a == 6'd1) return m_flags;
      else if (a == 6'd2) return m_cmp;
      else if (a >= 6'd16 && a <= 6'd31) return {4'h0, m_res[a - 6'd16]};
      return 16'h0000;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_flags = '0; m_cmp = '0; m_abort = 1'b0;
         for (int s = 0; s < 16; s++) m_res[s] = '0;
      end else begin
         logic [15:0] nf;
         logic        is_res;
         int          idx;
         is_res = bus_addr >= 16 && bus_addr <= 31;
         idx = int'(bus_addr) - 16;
         nf = m_flags;
         for (int s = 0; s < 16; s++) begin
            logic c;
            c = 1'b0;
            if (m_ctrl[6]) begin
               if (bus_sel && is_res && idx == s)
                  c = m_cmp[s] ? bus_wr : !bus_wr;
            end else if (bus_sel && bus_wr && bus_addr == 1 && bus_wdata[s])
               c = 1'b1;
            if (c) nf[s] = 1'b0;
            if (cv_done && cv_slot == s) nf[s] = 1'b1;
         end
         m_flags = nf;
         m_abort = bus_sel && bus_wr && bus_addr == 0;
         if (m_abort) m_ctrl = bus_wdata[7:0] & 8'h7F;
         if (bus_sel && bus_wr && bus_addr == 2) m_cmp = bus_wdata;
         if (bus_sel && bus_wr && is_res) m_res[idx] = bus_wdata[11:0];
         if (cv_done) m_res[cv_slot] = cv_result;
      end
   end

   always @(negedge clk) begin
      n_cyc++;
      chk(cur_req, "flags_o", 32'(flags_o), 32'(m_flags));
      chk(cur_req, "ctrl_o", 32'(ctrl_o), 32'(m_ctrl));
      chk(cur_req, "seq_abort_o", 32'(seq_abort_o), 32'(m_abort));
      if (n_cyc > 100000) begin
         chk("watchdog", "timeout", 32'd1, 32'd0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic cyc(input logic sel, input logic wr, input logic [5:0] a,
                      input logic [15:0] wd, input logic dn,
                      input logic [3:0] sl, input logic [11:0] rv);
      @(negedge clk);
      #1;
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      cv_done = dn; cv_slot = sl; cv_result = rv;
      #2;
      if (sel && !wr) chk(cur_req, "bus_rdata", 32'(bus_rdata), 32'(m_read(a)));
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      cyc(1, 1, a, d, 0, 0, 0);
   endtask
   task automatic rd(input logic [5:0] a);
      cyc(1, 0, a, 0, 0, 0, 0);
   endtask
   task automatic done(input logic [3:0] s, input logic [11:0] v);
      cyc(0, 0, 0, 0, 1, s, v);
   endtask
   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      rd(0); rd(1); rd(2); rd(16); rd(31);
      chk("R1", "flags after reset", 32'(flags_o), 32'h0);

      cur_req = "R2";
      wr(0, 16'hFFFF); rd(0);
      wr(0, 16'h002A); rd(0);
      cur_req = "R3";
      wr(0, 16'h0000); wr(0, 16'h0000); idle(); idle();

      cur_req = "R4";
      done(0, 12'hABC); done(5, 12'h123); done(15, 12'hFFF);
      rd(16); rd(21); rd(31); rd(1);

      cur_req = "R5";
      wr(1, 16'h0001); rd(1);
      wr(1, 16'h0000); rd(1);
      wr(1, 16'h8020); rd(1);

      cur_req = "R9";
      done(2, 12'h055); rd(18); wr(18, 16'h0777); rd(1);

      cur_req = "R11";
      wr(2, 16'hA5F0); rd(2); wr(2, 16'h0010); rd(2);

      cur_req = "R6";
      wr(0, 16'h0040); wr(1, 16'hFFFF); rd(1);

      cur_req = "R7";
      done(3, 12'h333); wr(19, 16'h0111); rd(1); rd(19); rd(1);
      cur_req = "R8";
      done(4, 12'h444); rd(20); rd(1); wr(20, 16'h0999); rd(1);

      cur_req = "R10";
      done(3, 12'h001);
      cyc(1, 0, 6'd19, 0, 1, 4'd3, 12'h002); rd(1);
      wr(0, 16'h0000);
      done(1, 12'h010);
      cyc(1, 1, 6'd1, 16'h0002, 1, 4'd1, 12'h011); rd(1);

      cur_req = "R12";
      cyc(1, 1, 6'd22, 16'hF456, 1, 4'd6, 12'h789); rd(22);
      cyc(1, 1, 6'd22, 16'h0321, 1, 4'd7, 12'h654); rd(22); rd(23);

      cur_req = "R13";
      rd(3); rd(15); rd(32); rd(63); rd(1);

      cur_req = "R3";
      for (int k = 0; k < 700; k++) begin
         logic [5:0] a;
         if (k % 50 == 0)       a = 6'd0;
         else if (k % 4 == 0)   a = 6'd1;
         else if (k % 9 == 1)   a = 6'd2;
         else                   a = 6'(16 + (k * 7) % 16);
         cyc(k % 3 != 0, k % 2 == 1, a, 16'(k * 40503),
             k % 3 == 1, 4'((k * 11) % 16), 12'(k * 37));
      end
      idle(); idle();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule